// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Pipeline

This block turns raw calorimeter readout into compressed trigger sums at one result per bunch-crossing clock. Every crossing it takes one nonlinear ADC code per channel for a group of channels. It maps each code to linear energy in 0.5 GeV units through a shared lookup table. Each energy is scaled by a per-channel fractional weight to give transverse energy, which is clamped at the 255 GeV full scale. The enabled channels are added with a saturating adder. The sum is re-encoded into a short output code through a second lookup table and handed to the trigger link logic.

Both tables are double-buffered. A host write port loads the shadow copy of either table. The loaded copy becomes active only at a bunch-zero marker, so a table never changes partway through an orbit. The bunch-zero marker travels through the block with the data and leaves it together with the output word of crossing zero. The latency is fixed at four clocks.

Top module: `tpg_pipeline`

## Requirements
- R1: The output code for the channel codes sampled at one clock edge appears on `tp_code` after the third following edge. The latency is four clocks, and a new result is produced on every clock.
- R2: Every channel code `c` (channel i in bits `adc_codes[7i+6:7i]`) is converted to linear energy `L[c]`, a 10-bit value in 0.5 GeV units. `L` is one 128-entry table shared by all channels.
- R3: The transverse energy of channel i is `floor(L[c] * w / 256)`, where `w` is `ch_weight[8i+7:8i]`. When this value is above 510 (255 GeV) the result is 510.
- R4: The sum adds the transverse energies of the enabled channels. When the total is above 1023 the sum is 1023; it never wraps.
- R5: A channel whose `ch_mask[i]` bit is 0 adds nothing to the sum. With all mask bits clear, the sum is 0.
- R6: The output code is `C[s]`, where `s` is the 10-bit sum and `C` is a 1024-entry table of 8-bit codes.
- R7: A host write with `host_wr_sel`=0 stores `host_wr_data[9:0]` at code `host_wr_addr[6:0]` of the shadow linearization table. With `host_wr_sel`=1 it stores `host_wr_data[7:0]` at sum `host_wr_addr[9:0]` of the shadow compression table. Writes do not change `tp_code`. After at least one write to a table, the next `bz_in` makes its shadow copy active, starting with the crossing that carries the marker. The host is expected to load a complete table before the marker.
- R8: `bz_out` equals `bz_in` delayed by four clocks, so it is high with the output word of the marked crossing.
- R9: While `rst_n` is low at a clock edge, `tp_code` and `bz_out` are 0 after that edge.
- R10: A `bz_in` that arrives with no write to a table since that table's last swap leaves the active copy of that table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_codes | input | NCH*ADC_W (49) | Raw code per channel, channel i in slice i |
| bz_in | input | 1 | Bunch-zero marker for the crossing on `adc_codes` |
| ch_weight | input | NCH*WT_W (56) | Per-channel transverse-energy weight, value/256 |
| ch_mask | input | NCH (7) | Per-channel sum enable |
| host_wr_en | input | 1 | Host table write strobe |
| host_wr_sel | input | 1 | 0 selects the linearization table, 1 selects the compression table |
| host_wr_addr | input | 10 | Table address |
| host_wr_data | input | 10 | Table entry |
| tp_code | output | OUT_W (8) | Compressed trigger sum |
| bz_out | output | 1 | Bunch-zero marker aligned with `tp_code` |

## Verification
The bench builds the block with its default parameters: seven channels, 7-bit codes, 10-bit energies and sums, and 8-bit weights and output codes. At this size every linearization entry and every compression entry can be written and then exercised. The bench sweeps all 128 codes on every channel under several weight and mask settings. All-maximum inputs drive both the per-channel clamp at 510 and the sum saturation at 1023. Two distinct table sets make it visible at the outputs whether a swap took place, did not take place, or took place at the wrong crossing.

// File: rtl/tpg_pkg.sv
// Package: shared types and constants of the trigger primitive pipeline.
package tpg_pkg;

    // Host table select encoding.
    typedef enum logic {
        TBL_LIN  = 1'b0,
        TBL_COMP = 1'b1
    } tbl_sel_e;

    // Register stages from input sampling to output word.
    localparam int TPG_LATENCY = 4;

endpackage

// File: rtl/tpg_bank_table.sv
// Module: tpg_bank_table
// Double-buffered lookup table with NRD registered read ports.
// Host writes always land in the shadow bank and set a pending flag.
// When swap_req is high and a write is pending, the banks exchange
// roles at that edge. The reads taken at that same edge already use
// the new bank. Assumes the host fills the whole shadow bank before
// requesting a swap; table contents are not reset.
module tpg_bank_table #(
    parameter int AW  = 7,
    parameter int DW  = 10,
    parameter int NRD = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               swap_req,
    input  logic [NRD*AW-1:0]  rd_addr,
    output logic [NRD*DW-1:0]  rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank0 [DEPTH];
    logic [DW-1:0] bank1 [DEPTH];
    logic          act_q;
    logic          pend_q;
    logic          swap_now;
    logic          rd_bank;

    assign swap_now = swap_req & pend_q;
    assign rd_bank  = act_q ^ swap_now;

    // Track which bank is active and whether the shadow holds new data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (swap_now) begin
                act_q <= ~act_q;
            end
            if (wr_en) begin
                pend_q <= 1'b1;
            end else if (swap_now) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Shadow write into bank 0 while bank 1 is active.
    always_ff @(posedge clk) begin
        if (wr_en && act_q) begin
            bank0[wr_addr] <= wr_data;
        end
    end

    // Shadow write into bank 1 while bank 0 is active.
    always_ff @(posedge clk) begin
        if (wr_en && !act_q) begin
            bank1[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] a;
        assign a = rd_addr[p*AW +: AW];

        // Registered read of one port from the selected bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data[p*DW +: DW] <= '0;
            end else begin
                rd_data[p*DW +: DW] <= rd_bank ? bank1[a] : bank0[a];
            end
        end
    end

endmodule

// File: rtl/tpg_et_weight.sv
// Module: tpg_et_weight
// Converts each channel's linear energy to transverse energy by
// multiplying with an unsigned fractional weight (value / 2**WT_W).
// The product is truncated and clamped at ET_MAX. Registered output,
// one stage. Assumes the weights are quasi-static configuration.
module tpg_et_weight #(
    parameter int NCH    = 7,
    parameter int LIN_W  = 10,
    parameter int WT_W   = 8,
    parameter int ET_MAX = 510
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*LIN_W-1:0]  lin_flat,
    input  logic [NCH*WT_W-1:0]   weight_flat,
    output logic [NCH*LIN_W-1:0]  et_flat
);

    localparam int PW = LIN_W + WT_W;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [PW-1:0]    prod;
        logic [PW-1:0]    scaled;
        logic [LIN_W-1:0] et_d;

        // Scale, truncate and clamp one channel.
        always_comb begin
            prod   = PW'(lin_flat[i*LIN_W +: LIN_W]) * PW'(weight_flat[i*WT_W +: WT_W]);
            scaled = prod >> WT_W;
            if (scaled > PW'(ET_MAX)) begin
                et_d = LIN_W'(ET_MAX);
            end else begin
                et_d = scaled[LIN_W-1:0];
            end
        end

        // Register the transverse energy of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                et_flat[i*LIN_W +: LIN_W] <= '0;
            end else begin
                et_flat[i*LIN_W +: LIN_W] <= et_d;
            end
        end
    end

endmodule

// File: rtl/tpg_chan_sum.sv
// Module: tpg_chan_sum
// Adds the transverse energies of the channels enabled in the mask.
// The result saturates at the all-ones value of SUM_W. Registered
// output, one stage. Assumes the mask is quasi-static configuration.
module tpg_chan_sum #(
    parameter int NCH   = 7,
    parameter int ET_W  = 10,
    parameter int SUM_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*ET_W-1:0]  et_flat,
    input  logic [NCH-1:0]       mask,
    output logic [SUM_W-1:0]     sum_q
);

    localparam int ACC_W   = ET_W + $clog2(NCH + 1);
    localparam int SUM_TOP = (1 << SUM_W) - 1;

    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum_d;

    // Accumulate the enabled channels and saturate.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            if (mask[i]) begin
                acc = acc + ACC_W'(et_flat[i*ET_W +: ET_W]);
            end
        end
        if (acc > ACC_W'(SUM_TOP)) begin
            sum_d = SUM_W'(SUM_TOP);
        end else begin
            sum_d = acc[SUM_W-1:0];
        end
    end

    // Register the group sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/tpg_pipeline.sv
// Module: tpg_pipeline (top)
// Four-stage trigger primitive path: linearization lookup, transverse
// energy weighting, masked saturating sum, compression lookup. Each
// table swaps banks at the bunch-zero marker of the stage that reads
// it, so the whole marked crossing sees the new tables. Assumes the
// weights and mask change only between runs, or with a pipeline flush.
module tpg_pipeline #(
    parameter int NCH    = 7,
    parameter int ADC_W  = 7,
    parameter int LIN_W  = 10,
    parameter int WT_W   = 8,
    parameter int SUM_W  = 10,
    parameter int OUT_W  = 8,
    parameter int ET_MAX = 510,
    localparam int HA_W  = (ADC_W > SUM_W) ? ADC_W : SUM_W,
    localparam int HD_W  = (LIN_W > OUT_W) ? LIN_W : OUT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*ADC_W-1:0]  adc_codes,
    input  logic                  bz_in,
    input  logic [NCH*WT_W-1:0]   ch_weight,
    input  logic [NCH-1:0]        ch_mask,
    input  logic                  host_wr_en,
    input  logic                  host_wr_sel,
    input  logic [HA_W-1:0]       host_wr_addr,
    input  logic [HD_W-1:0]       host_wr_data,
    output logic [OUT_W-1:0]      tp_code,
    output logic                  bz_out
);

    import tpg_pkg::*;

    localparam int LAT = TPG_LATENCY;

    tbl_sel_e              wr_sel;
    logic                  lin_we;
    logic                  comp_we;
    logic [NCH*LIN_W-1:0]  lin_flat;
    logic [NCH*LIN_W-1:0]  et_flat;
    logic [SUM_W-1:0]      sum_q;
    logic [LAT-1:0]        bz_pipe;

    assign wr_sel  = tbl_sel_e'(host_wr_sel);
    assign lin_we  = host_wr_en && (wr_sel == TBL_LIN);
    assign comp_we = host_wr_en && (wr_sel == TBL_COMP);

    // Bits of the shared host port that a narrower table ignores.
    if (HA_W > ADC_W) begin : g_addr_spare
        logic unused_addr_hi;
        assign unused_addr_hi = ^host_wr_addr[HA_W-1:ADC_W];
    end
    if (HD_W > OUT_W) begin : g_data_spare
        logic unused_data_hi;
        assign unused_data_hi = ^host_wr_data[HD_W-1:OUT_W];
    end

    // Stage 1: linearization, one read port per channel.
    tpg_bank_table #(
        .AW  (ADC_W),
        .DW  (LIN_W),
        .NRD (NCH)
    ) u_lin_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lin_we),
        .wr_addr  (host_wr_addr[ADC_W-1:0]),
        .wr_data  (host_wr_data[LIN_W-1:0]),
        .swap_req (bz_in),
        .rd_addr  (adc_codes),
        .rd_data  (lin_flat)
    );

    // Stage 2: transverse energy.
    tpg_et_weight #(
        .NCH    (NCH),
        .LIN_W  (LIN_W),
        .WT_W   (WT_W),
        .ET_MAX (ET_MAX)
    ) u_et (
        .clk         (clk),
        .rst_n       (rst_n),
        .lin_flat    (lin_flat),
        .weight_flat (ch_weight),
        .et_flat     (et_flat)
    );

    // Stage 3: masked saturating sum.
    tpg_chan_sum #(
        .NCH   (NCH),
        .ET_W  (LIN_W),
        .SUM_W (SUM_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .et_flat (et_flat),
        .mask    (ch_mask),
        .sum_q   (sum_q)
    );

    // Stage 4: compression; swaps when the marker sits beside sum_q.
    tpg_bank_table #(
        .AW  (SUM_W),
        .DW  (OUT_W),
        .NRD (1)
    ) u_comp_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (comp_we),
        .wr_addr  (host_wr_addr[SUM_W-1:0]),
        .wr_data  (host_wr_data[OUT_W-1:0]),
        .swap_req (bz_pipe[LAT-2]),
        .rd_addr  (sum_q),
        .rd_data  (tp_code)
    );

    // Carry the bunch-zero marker alongside the data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bz_pipe <= '0;
        end else begin
            bz_pipe <= {bz_pipe[LAT-2:0], bz_in};
        end
    end

    assign bz_out = bz_pipe[LAT-1];

endmodule

// File: rtl/tpg_pipeline_chk.sv
// Module: tpg_pipeline_chk
// Property checker bound into tpg_pipeline. Observes the top-level
// ports and the stage boundaries between the weighting and sum blocks.
module tpg_pipeline_chk #(
    parameter int NCH    = 7,
    parameter int ET_W   = 10,
    parameter int SUM_W  = 10,
    parameter int OUT_W  = 8,
    parameter int ET_MAX = 510
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bz_in,
    input logic                 bz_out,
    input logic [OUT_W-1:0]     tp_code,
    input logic [NCH*ET_W-1:0]  et_flat,
    input logic [NCH-1:0]       ch_mask,
    input logic [SUM_W-1:0]     sum_q
);

    logic [2:0] live_cnt;

    // Count edges since reset release, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 3'd7) begin
            live_cnt <= live_cnt + 3'd1;
        end
    end

    // R9: reset clears the output word and the marker.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (tp_code == '0 && !bz_out));

    // R8: marker leaves four clocks after it entered.
    assert_bz_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd4) |-> (bz_out == $past(bz_in, 4)));

    // R5: an all-clear mask yields a zero sum.
    assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != 3'd0 && $past(ch_mask) == '0) |-> (sum_q == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3: transverse energy never exceeds full scale.
        assert_et_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
            et_flat[i*ET_W +: ET_W] <= ET_W'(ET_MAX));

        // R4: a saturating sum is never below any enabled term.
        assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (live_cnt != 3'd0 && $past(ch_mask[i]))
            |-> (sum_q >= $past(et_flat[i*ET_W +: ET_W])));
    end

endmodule

bind tpg_pipeline tpg_pipeline_chk #(
    .NCH    (NCH),
    .ET_W   (LIN_W),
    .SUM_W  (SUM_W),
    .OUT_W  (OUT_W),
    .ET_MAX (ET_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bz_in   (bz_in),
    .bz_out  (bz_out),
    .tp_code (tp_code),
    .et_flat (et_flat),
    .ch_mask (ch_mask),
    .sum_q   (sum_q)
);

// File: tb/sim_tpg_pipeline.sv
// Bench: streams crossings into tpg_pipeline and compares every output
// word and marker against an arithmetic model of the requirements.
module sim_tpg_pipeline;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 7;
    localparam int AW   = 7;
    localparam int WW   = 8;
    localparam int LAT  = 4;
    localparam int NLIN = 128;
    localparam int NCMP = 1024;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NCH*AW-1:0]    adc_codes;
    logic                 bz_in;
    logic [NCH*WW-1:0]    ch_weight;
    logic [NCH-1:0]       ch_mask;
    logic                 host_wr_en;
    logic                 host_wr_sel;
    logic [9:0]           host_wr_addr;
    logic [9:0]           host_wr_data;
    logic [7:0]           tp_code;
    logic                 bz_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpg_pipeline u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_codes    (adc_codes),
        .bz_in        (bz_in),
        .ch_weight    (ch_weight),
        .ch_mask      (ch_mask),
        .host_wr_en   (host_wr_en),
        .host_wr_sel  (host_wr_sel),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .tp_code      (tp_code),
        .bz_out       (bz_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state.
    int m_lin [2][NLIN];
    int m_cmp [2][NCMP];
    int m_lin_act = 0;
    int m_cmp_act = 0;
    bit m_lin_pend = 1'b0;
    bit m_cmp_pend = 1'b0;
    bit m_lin_ld = 1'b0;
    bit m_cmp_ld = 1'b0;

    // Expected-value ring indexed by crossing number.
    bit    r_have [LAT];
    bit    r_live [LAT];
    int    r_out  [LAT];
    bit    r_bz   [LAT];
    string r_tag  [LAT];
    int    cyc = 0;

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (crossing %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int model_out(input logic [NCH*AW-1:0] codes);
        int s = 0;
        for (int i = 0; i < NCH; i++) begin
            int l;
            int e;
            l = m_lin[m_lin_act][int'(codes[i*AW +: AW])];
            e = (l * int'(ch_weight[i*WW +: WW])) / 256;
            if (e > 510) e = 510;
            if (ch_mask[i]) s += e;
        end
        if (s > 1023) s = 1023;
        return m_cmp[m_cmp_act][s];
    endfunction

    function automatic logic [NCH*AW-1:0] codes_for(input int k, input int pat);
        logic [NCH*AW-1:0] c;
        for (int i = 0; i < NCH; i++) begin
            c[i*AW +: AW] = 7'((k * (i + 1) + 19 * i + pat * 37) % 128);
        end
        return c;
    endfunction

    // One crossing: check the crossing four back, model and drive this one.
    task automatic tick(input logic [NCH*AW-1:0] codes, input bit bz, input bit we,
                        input bit sel, input int addr, input int data, input string tag);
        int slot;
        @(negedge clk);
        slot = cyc % LAT;
        if (r_have[slot]) begin
            if (r_live[slot]) check(int'(tp_code), r_out[slot], r_tag[slot]);
            check(int'(bz_out), int'(r_bz[slot]), "R8 marker alignment");
        end
        if (bz) begin
            if (m_lin_pend) begin m_lin_act = 1 - m_lin_act; m_lin_pend = 1'b0; m_lin_ld = 1'b1; end
            if (m_cmp_pend) begin m_cmp_act = 1 - m_cmp_act; m_cmp_pend = 1'b0; m_cmp_ld = 1'b1; end
        end
        r_have[slot] = 1'b1;
        r_live[slot] = m_lin_ld && m_cmp_ld;
        r_out[slot]  = model_out(codes);
        r_bz[slot]   = bz;
        r_tag[slot]  = tag;
        if (we) begin
            if (!sel) begin m_lin[1 - m_lin_act][addr] = data; m_lin_pend = 1'b1; end
            else      begin m_cmp[1 - m_cmp_act][addr] = data; m_cmp_pend = 1'b1; end
        end
        adc_codes    = codes;
        bz_in        = bz;
        host_wr_en   = we;
        host_wr_sel  = sel;
        host_wr_addr = 10'(addr);
        host_wr_data = 10'(data);
        cyc++;
    endtask

    // Change configuration; crossings already in flight are not compared.
    task automatic set_cfg(input logic [NCH*WW-1:0] w, input logic [NCH-1:0] m);
        ch_weight = w;
        ch_mask   = m;
        for (int i = 0; i < LAT; i++) r_live[i] = 1'b0;
    endtask

    function automatic logic [NCH*WW-1:0] flat_w(input int base, input int step);
        logic [NCH*WW-1:0] w;
        for (int i = 0; i < NCH; i++) w[i*WW +: WW] = 8'((base + step * i) % 256);
        return w;
    endfunction

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(codes_for(i, 3), 1'b0, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic sweep(input int pat, input string tag);
        for (int k = 0; k < NLIN; k++) tick(codes_for(k, pat), (k % 37) == 20, 1'b0, 1'b0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LAT; i++) begin r_have[i] = 1'b0; r_live[i] = 1'b0; end
        rst_n = 1'b0; adc_codes = '0; bz_in = 1'b0; host_wr_en = 1'b0;
        host_wr_sel = 1'b0; host_wr_addr = '0; host_wr_data = '0;
        ch_weight = flat_w(255, 0); ch_mask = '1;
        repeat (3) @(negedge clk);
        check(int'(tp_code), 0, "R9 reset output");
        check(int'(bz_out), 0, "R9 reset marker");
        rst_n = 1'b1;

        // Table set A: L[c]=8c, C[s]=s/4; activated by a marker.
        for (int c = 0; c < NLIN; c++) tick(codes_for(c, 1), 1'b0, 1'b1, 1'b0, c, 8 * c, "load");
        for (int s = 0; s < NCMP; s++) tick(codes_for(s, 1), 1'b0, 1'b1, 1'b1, s, s / 4, "load");
        idle(2, "load");
        tick(codes_for(5, 2), 1'b1, 1'b0, 1'b0, 0, 0, "R7 first swap at marked crossing");
        sweep(0, "R1 R2 R3 R4 R6 full weight, all channels");

        set_cfg(flat_w(15, 36), 7'h55);
        sweep(1, "R3 R5 mixed weights, partial mask");
        set_cfg(flat_w(200, 9), 7'h00);
        sweep(2, "R5 all channels masked");
        set_cfg(flat_w(130, 0), 7'h7F);
        for (int k = 0; k < 8; k++) tick({NCH{7'd127}}, 1'b0, 1'b0, 1'b0, 0, 0, "R3 R4 full-scale clamp and saturation");
        set_cfg(flat_w(128, 0), 7'h01);
        for (int k = 0; k < 8; k++) tick({NCH{7'd127}}, 1'b0, 1'b0, 1'b0, 0, 0, "R3 just below clamp");
        set_cfg(flat_w(255, 0), 7'h7F);
        sweep(3, "R1 R2 R6 back-to-back crossings");

        // Table set B for linearization, loaded while traffic flows.
        for (int c = 0; c < NLIN; c++) tick(codes_for(c, 4), 1'b0, 1'b1, 1'b0, c, (c * c) / 16, "R7 shadow write has no effect");
        idle(LAT, "R7 shadow write has no effect");
        tick(codes_for(9, 5), 1'b1, 1'b0, 1'b0, 0, 0, "R7 linearization swap");
        sweep(5, "R2 R7 new linearization, old compression");

        // Table set B for compression.
        for (int s = 0; s < NCMP; s++) tick(codes_for(s, 6), 1'b0, 1'b1, 1'b1, s, (s * 5 + 3) % 256, "R7 shadow write has no effect");
        idle(LAT, "R7 shadow write has no effect");
        tick(codes_for(11, 7), 1'b1, 1'b0, 1'b0, 0, 0, "R7 compression swap");
        sweep(7, "R6 R7 new compression");

        // Markers with nothing pending keep the tables.
        for (int k = 0; k < 6; k++) tick(codes_for(k, 8), 1'b1, 1'b0, 1'b0, 0, 0, "R10 marker without writes");
        sweep(9, "R10 tables kept after idle markers");
        idle(LAT + 1, "R1 drain");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule